// File: doc/BRIEF.md
# Stride-Pipelined Range-Match Traffic Classifier

This block assigns a class label to a stream of feature vectors using a table of range rules. Each rule row stands for one root-to-leaf path of a trained decision tree. It stores an inclusive lower and upper bound for every feature, a class label and a valid bit. A feature vector is accepted on every clock. It descends through the rows of a two-dimensional array of small compare elements. Each element looks at one fixed-width slice (stride) of one feature. Comparison state moves sideways along a row, most significant stride first. The row's verdict then joins a top-to-bottom priority chain. The class of the highest matching row, or a miss flag with class zero, leaves the array after a fixed latency. Results keep their input order.

Rule contents are written one bit per clock through a scan path that snakes through the compare elements of the selected row. The array holds one row more than the nominal rule count. A replacement rule can therefore be loaded into the spare row while the old rule keeps serving traffic, and the old row is retired afterwards. A row that is being shifted is kept from matching, so a half-written rule never classifies a packet.

Top module: `rmc_classifier`

## Requirements
- R1: One feature vector can be accepted per clock. For a vector sampled with `in_valid` high at clock edge k, `out_valid` is high in the cycle after edge k + NUM_RULES + 1 + STRIDES and low one cycle earlier. Back-to-back inputs produce back-to-back results in input order.
- R2: A row matches when, for every feature, lower bound <= feature <= upper bound. Both bounds are inclusive and the comparison is on the unsigned value. Feature f occupies `in_feat[f*FEAT_W +: FEAT_W]`, where FEAT_W = STRIDES*STRIDE_W.
- R3: Strides are compared most significant first. A decision made in a higher stride is not overturned by a lower stride, so values whose high strides differ, or whose high strides are equal and low strides differ, compare by their full numeric value.
- R4: When several rows match, the row with the lowest index supplies the class.
- R5: A vector that matches no row produces `out_valid` high, `out_miss` high and `out_class` equal to zero.
- R6: A row whose valid bit is 0 never matches, whatever its bounds hold.
- R7: While `scan_en` is high, the row addressed by `scan_row` shifts one bit per clock from `scan_in`, and all other rows keep their contents. The row word is shifted most significant bit first. Its low CLS_W+1 bits are {valid, class}. Above them come the compare cells in chain order, 2*STRIDE_W bits each, laid out as {upper stride, lower stride}. The chain visits feature 0 from its most significant stride down, then feature 1 from its least significant stride up, and keeps alternating.
- R8: A row never matches while it is being shifted. The other rows keep classifying during the shift.
- R9: The array has NUM_RULES+1 rows. The last (spare) row is loadable and classifies like any other row, with the lowest priority.
- R10: After reset every row is invalid, so every vector misses, and `out_valid` is low until a result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Feature vector present this cycle |
| in_feat | input | NUM_FEAT*STRIDES*STRIDE_W | Packed feature vector, feature 0 in the low bits |
| scan_en | input | 1 | Shift the addressed row by one bit |
| scan_row | input | $clog2(NUM_RULES+1) | Row being written |
| scan_in | input | 1 | Serial rule data, MSB of the row word first |
| out_valid | output | 1 | Result present this cycle |
| out_miss | output | 1 | No row matched the vector |
| out_class | output | CLS_W | Class of the highest matching row, zero on a miss |

## Verification
A wrong comparison state inside one element shows up at the ports as a wrong class or a spurious miss. That result appears exactly NUM_RULES+1+STRIDES cycles after the affected vector, and only for vectors whose values sit on a stride boundary of that rule. The bench therefore picks values that agree in the high stride and differ in the low one, and values that disagree in both. A broken priority chain lets a lower row overwrite a higher row's class, so some vectors are chosen to match two rows at once. Faults in the scan path or in the shift gating show up on the first vector that reaches the rewritten row during or after the load.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Relation of a feature to a boundary, settled most significant stride first.
   typedef enum logic [1:0] {
      CMP_EQ = 2'b00,
      CMP_LT = 2'b01,
      CMP_GT = 2'b10
   } cmp_e;

   // Position of the cell (feature f, stride s) on a row's serpentine write chain.
   // Position 0 is the row tag; cells follow, direction alternating per feature.
   function automatic int chain_pos(input int f, input int s, input int strides);
      return f * strides + (((f % 2) == 1) ? (strides - 1 - s) : s) + 1;
   endfunction
endpackage

// File: rtl/rmc_pe.sv
module rmc_pe
   import rmc_pkg::*;
#(
   parameter int STRIDE_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STRIDE_W-1:0] f_in,
   output logic [STRIDE_W-1:0] f_out,
   input  cmp_e                lo_st_in,
   input  cmp_e                hi_st_in,
   output cmp_e                lo_st_out,
   output cmp_e                hi_st_out,
   input  logic                wr_en,
   input  logic                wr_in,
   output logic                wr_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CELL_W = 2 * STRIDE_W;

   logic [CELL_W-1:0]   cell_q;
   logic [STRIDE_W-1:0] lo_b;
   logic [STRIDE_W-1:0] hi_b;

   assign {hi_b, lo_b} = cell_q;
   assign wr_out       = cell_q[CELL_W-1];

   function automatic cmp_e step(input cmp_e prev, input logic [STRIDE_W-1:0] a,
                                 input logic [STRIDE_W-1:0] b);
      if (prev != CMP_EQ) return prev;
      if (a < b) return CMP_LT;
      if (a > b) return CMP_GT;
      return CMP_EQ;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cell_q    <= '0;
         f_out     <= '0;
         lo_st_out <= CMP_EQ;
         hi_st_out <= CMP_EQ;
      end else begin
         if (wr_en) cell_q <= {cell_q[CELL_W-2:0], wr_in};
         f_out     <= f_in;
         lo_st_out <= step(lo_st_in, f_in, lo_b);
         hi_st_out <= step(hi_st_in, f_in, hi_b);
      end
   end

   // A relation settled in a higher stride must pass through unchanged.
   assert_lo_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_st_in != CMP_EQ) |=> (lo_st_out == $past(lo_st_in)));
   assert_hi_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_st_in != CMP_EQ) |=> (hi_st_out == $past(hi_st_in)));
endmodule

// File: rtl/rmc_row.sv
module rmc_row
   import rmc_pkg::*;
#(
   parameter int NUM_FEAT = 6,
   parameter int STRIDES  = 4,
   parameter int STRIDE_W = 3,
   parameter int CLS_W    = 3
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic [NUM_FEAT-1:0][STRIDES-1:0][STRIDE_W-1:0] f_in,
   output logic [NUM_FEAT-1:0][STRIDES-1:0][STRIDE_W-1:0] f_out,
   input  logic                                          scan_sel,
   input  logic                                          scan_in,
   input  logic                                          dec_hit_in,
   input  logic [CLS_W-1:0]                              dec_cls_in,
   output logic                                          dec_hit_out,
   output logic [CLS_W-1:0]                              dec_cls_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NPE   = NUM_FEAT * STRIDES;
   localparam int TAG_W = CLS_W + 1;

   logic [TAG_W-1:0]    tag_q;
   logic [NPE:0]        chain;
   logic [NUM_FEAT-1:0] feat_ok;
   logic                row_live;
   logic                row_match;
   logic                unused_tail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_q <= '0;
      else if (scan_sel) tag_q <= {tag_q[TAG_W-2:0], scan_in};
   end

   assign chain[0]    = tag_q[TAG_W-1];
   assign unused_tail = chain[NPE];

   for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
      cmp_e lo_c [STRIDES+1];
      cmp_e hi_c [STRIDES+1];
      assign lo_c[0] = CMP_EQ;
      assign hi_c[0] = CMP_EQ;

      for (genvar s = 0; s < STRIDES; s++) begin : g_stride
         localparam int POS = chain_pos(f, s, STRIDES);
         rmc_pe #(.STRIDE_W(STRIDE_W)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .f_in     (f_in[f][s]),
            .f_out    (f_out[f][s]),
            .lo_st_in (lo_c[s]),
            .hi_st_in (hi_c[s]),
            .lo_st_out(lo_c[s+1]),
            .hi_st_out(hi_c[s+1]),
            .wr_en    (scan_sel),
            .wr_in    (chain[POS-1]),
            .wr_out   (chain[POS])
         );
      end

      assign feat_ok[f] = (lo_c[STRIDES] != CMP_LT) && (hi_c[STRIDES] != CMP_GT);
   end

   assign row_live  = tag_q[TAG_W-1] && !scan_sel;
   assign row_match = row_live && (&feat_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_hit_out <= 1'b0;
         dec_cls_out <= '0;
      end else begin
         dec_hit_out <= dec_hit_in || row_match;
         if (dec_hit_in)     dec_cls_out <= dec_cls_in;
         else if (row_match) dec_cls_out <= tag_q[CLS_W-1:0];
         else                dec_cls_out <= '0;
      end
   end

   assert_upper_row_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit_in |=> (dec_hit_out && (dec_cls_out == $past(dec_cls_in))));
   assert_shift_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_sel && !dec_hit_in) |=> !dec_hit_out);
   assert_invalid_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tag_q[TAG_W-1] && !dec_hit_in) |=> !dec_hit_out);
endmodule

// File: rtl/rmc_classifier.sv
module rmc_classifier
   import rmc_pkg::*;
#(
   parameter int NUM_FEAT  = 6,
   parameter int STRIDES   = 4,
   parameter int STRIDE_W  = 3,
   parameter int NUM_RULES = 96,
   parameter int CLS_W     = 3,
   localparam int FEAT_W    = STRIDES * STRIDE_W,
   localparam int NROWS     = NUM_RULES + 1,
   localparam int ROW_IDX_W = (NROWS > 1) ? $clog2(NROWS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [NUM_FEAT*FEAT_W-1:0] in_feat,
   input  logic                       scan_en,
   input  logic [ROW_IDX_W-1:0]       scan_row,
   input  logic                       scan_in,
   output logic                       out_valid,
   output logic                       out_miss,
   output logic [CLS_W-1:0]           out_class
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LAT = NROWS + STRIDES;

   if (NUM_FEAT < 1 || STRIDES < 1 || STRIDE_W < 1 || NUM_RULES < 1 || CLS_W < 1)
   begin : g_bad_cfg
      $error("rmc_classifier: every size parameter must be at least 1");
   end

   logic [NUM_FEAT-1:0][STRIDES-1:0][STRIDE_W-1:0] skew_v;
   logic [NUM_FEAT-1:0][STRIDES-1:0][STRIDE_W-1:0] fv [NROWS+1];
   logic [NROWS:0]   hit_c;
   logic [CLS_W-1:0] cls_c [NROWS+1];
   logic [NROWS-1:0] row_sel;
   logic [LAT:0]     vq;
   logic             hit_q;
   logic [CLS_W-1:0] cls_q;
   logic             unused_fv;

   // Input skew: stride s (0 = most significant) is delayed s cycles.
   for (genvar f = 0; f < NUM_FEAT; f++) begin : g_skf
      for (genvar s = 0; s < STRIDES; s++) begin : g_sks
         localparam int LSB = f * FEAT_W + (STRIDES - 1 - s) * STRIDE_W;
         if (s == 0) begin : g_direct
            assign skew_v[f][s] = in_feat[LSB +: STRIDE_W];
         end else begin : g_delay
            logic [STRIDE_W-1:0] dly [s];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  for (int i = 0; i < s; i++) dly[i] <= '0;
               end else begin
                  dly[0] <= in_feat[LSB +: STRIDE_W];
                  for (int i = 1; i < s; i++) dly[i] <= dly[i-1];
               end
            end
            assign skew_v[f][s] = dly[s-1];
         end
      end
   end

   assign fv[0]     = skew_v;
   assign hit_c[0]  = 1'b0;
   assign cls_c[0]  = '0;
   assign unused_fv = ^fv[NROWS];

   for (genvar r = 0; r < NROWS; r++) begin : g_row
      assign row_sel[r] = scan_en && (scan_row == ROW_IDX_W'(r));
      rmc_row #(
         .NUM_FEAT(NUM_FEAT),
         .STRIDES (STRIDES),
         .STRIDE_W(STRIDE_W),
         .CLS_W   (CLS_W)
      ) u_row (
         .clk        (clk),
         .rst_n      (rst_n),
         .f_in       (fv[r]),
         .f_out      (fv[r+1]),
         .scan_sel   (row_sel[r]),
         .scan_in    (scan_in),
         .dec_hit_in (hit_c[r]),
         .dec_cls_in (cls_c[r]),
         .dec_hit_out(hit_c[r+1]),
         .dec_cls_out(cls_c[r+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vq    <= '0;
         hit_q <= 1'b0;
         cls_q <= '0;
      end else begin
         vq    <= {vq[LAT-1:0], in_valid};
         hit_q <= hit_c[NROWS];
         cls_q <= hit_c[NROWS] ? cls_c[NROWS] : '0;
      end
   end

   assign out_valid = vq[LAT];
   assign out_miss  = vq[LAT] && !hit_q;
   assign out_class = cls_q;

   assert_miss_zero_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_miss) |-> (out_class == '0));
   assert_miss_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_miss |-> out_valid);
endmodule

// File: tb/rmc_classifier_test.sv
module rmc_classifier_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NF = 2, ST = 2, SW = 3, NR = 3, CW = 3;
   localparam int FW = ST * SW;
   localparam int LAT = NR + 1 + ST;
   localparam int ROW_BITS = (CW + 1) + NF * ST * 2 * SW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [NF*FW-1:0] in_feat = '0;
   logic scan_en = 1'b0;
   logic [1:0] scan_row = '0;
   logic scan_in = 1'b0;
   logic out_valid, out_miss;
   logic [CW-1:0] out_class;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rmc_classifier #(.NUM_FEAT(NF), .STRIDES(ST), .STRIDE_W(SW), .NUM_RULES(NR), .CLS_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_feat(in_feat),
      .scan_en(scan_en), .scan_row(scan_row), .scan_in(scan_in),
      .out_valid(out_valid), .out_miss(out_miss), .out_class(out_class));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", what, act, exp);
      end
   endtask

   // Row word per R7: tag in low bits, cells in serpentine chain order above.
   function automatic logic [ROW_BITS-1:0] rule_word(input logic [5:0] lo0, input logic [5:0] hi0,
      input logic [5:0] lo1, input logic [5:0] hi1, input logic [2:0] cls, input logic vld);
      logic [ROW_BITS-1:0] w;
      logic [5:0] lo [2];
      logic [5:0] hi [2];
      lo[0] = lo0; lo[1] = lo1; hi[0] = hi0; hi[1] = hi1;
      w = '0;
      w[CW:0] = {vld, cls};
      for (int f = 0; f < NF; f++) begin
         for (int s = 0; s < ST; s++) begin
            int pos;
            pos = f * ST + (((f % 2) == 1) ? (ST - 1 - s) : s) + 1;
            w[(CW + 1) + (pos - 1) * 2 * SW +: 2 * SW] =
               {hi[f][(ST - 1 - s) * SW +: SW], lo[f][(ST - 1 - s) * SW +: SW]};
         end
      end
      return w;
   endfunction

   task automatic load_row(input int r, input logic [ROW_BITS-1:0] w);
      scan_row = 2'(r);
      scan_en = 1'b1;
      for (int i = ROW_BITS - 1; i >= 0; i--) begin
         scan_in = w[i];
         @(negedge clk);
      end
      scan_en = 1'b0;
   endtask

   task automatic classify(input logic [5:0] a, input logic [5:0] b, input logic exp_miss,
                           input logic [2:0] exp_cls, input string req);
      in_feat = {b, a};
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      chk({req, " valid before latency"}, out_valid, 0);
      @(negedge clk);
      chk({req, " valid"}, out_valid, 1);
      chk({req, " miss"}, out_miss, exp_miss);
      chk({req, " class"}, out_class, exp_cls);
   endtask

   task automatic t_reset;
      chk("R10 out_valid after reset", out_valid, 0);
      chk("R10 out_miss after reset", out_miss, 0);
      classify(6'd0, 6'd0, 1'b1, 3'd0, "R10 empty table");
   endtask

   task automatic t_load;
      load_row(0, rule_word(6'd10, 6'd20, 6'd0, 6'd63, 3'd3, 1'b1));
      load_row(1, rule_word(6'd15, 6'd40, 6'd30, 6'd35, 3'd5, 1'b1));
      load_row(2, rule_word(6'd0, 6'd63, 6'd50, 6'd63, 3'd6, 1'b1));
      classify(6'd12, 6'd5, 1'b0, 3'd3, "R7 row0 loaded");
   endtask

   task automatic t_bounds;
      classify(6'd10, 6'd0, 1'b0, 3'd3, "R2 lower bounds inclusive");
      classify(6'd20, 6'd63, 1'b0, 3'd3, "R2 upper bounds inclusive");
      classify(6'd21, 6'd5, 1'b1, 3'd0, "R2 above upper");
      classify(6'd9, 6'd5, 1'b1, 3'd0, "R2 below lower");
   endtask

   task automatic t_strides;
      classify(6'd23, 6'd32, 1'b0, 3'd5, "R3 equal high stride, low stride over");
      classify(6'd7, 6'd55, 1'b0, 3'd6, "R3 high stride decides");
      classify(6'd16, 6'd33, 1'b0, 3'd3, "R3 stride carry inside range");
   endtask

   task automatic t_priority;
      classify(6'd18, 6'd55, 1'b0, 3'd3, "R4 rows 0 and 2");
      classify(6'd16, 6'd32, 1'b0, 3'd3, "R4 rows 0 and 1");
      classify(6'd30, 6'd55, 1'b0, 3'd6, "R4 only row 2");
   endtask

   task automatic t_miss;
      classify(6'd40, 6'd40, 1'b1, 3'd0, "R5 no row");
      classify(6'd63, 6'd0, 1'b1, 3'd0, "R5 corner no row");
   endtask

   task automatic t_stream;
      logic [11:0] pk [4];
      logic        em [4];
      logic [2:0]  ec [4];
      pk[0] = {6'd5, 6'd12};  em[0] = 1'b0; ec[0] = 3'd3;
      pk[1] = {6'd33, 6'd30}; em[1] = 1'b0; ec[1] = 3'd5;
      pk[2] = {6'd5, 6'd9};   em[2] = 1'b1; ec[2] = 3'd0;
      pk[3] = {6'd55, 6'd1};  em[3] = 1'b0; ec[3] = 3'd6;
      for (int i = 0; i < 4; i++) begin
         in_feat = pk[i];
         in_valid = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (LAT - 4) @(negedge clk);
      chk("R1 stream not yet valid", out_valid, 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1 stream valid", out_valid, 1);
         chk("R1 stream miss order", out_miss, em[i]);
         chk("R1 stream class order", out_class, ec[i]);
      end
      @(negedge clk);
      chk("R1 stream ends", out_valid, 0);
   endtask

   task automatic t_spare;
      load_row(3, rule_word(6'd0, 6'd63, 6'd0, 6'd63, 3'd7, 1'b1));
      classify(6'd9, 6'd5, 1'b0, 3'd7, "R9 spare row matches");
      classify(6'd12, 6'd5, 1'b0, 3'd3, "R9 spare row lowest priority");
      load_row(3, rule_word(6'd0, 6'd63, 6'd0, 6'd63, 3'd7, 1'b0));
      classify(6'd9, 6'd5, 1'b1, 3'd0, "R6 invalid row ignored");
   endtask

   task automatic t_shift;
      // Row 0 shifts ones while the vector passes; unblocked it would hit as class 7.
      scan_row = 2'd0;
      scan_in = 1'b1;
      scan_en = 1'b1;
      classify(6'd12, 6'd5, 1'b1, 3'd0, "R8 row under shift blocked");
      classify(6'd30, 6'd33, 1'b0, 3'd5, "R8 other rows live during shift");
      scan_en = 1'b0;
      scan_in = 1'b0;
      load_row(0, rule_word(6'd10, 6'd20, 6'd0, 6'd63, 3'd3, 1'b1));
      classify(6'd12, 6'd5, 1'b0, 3'd3, "R7 row0 reloaded");
      classify(6'd30, 6'd33, 1'b0, 3'd5, "R7 row1 kept during row0 load");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_load;
      t_bounds;
      t_strides;
      t_priority;
      t_miss;
      t_stream;
      t_spare;
      t_shift;
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule